// File: doc/BRIEF.md
# Scaled 48-bit Real-Time Counter

This block is a free-running real-time counter for an always-powered domain. A 48-bit count advances by one on every cycle in which the timebase tick input is high and counting is enabled. The tick is normally a 31250 Hz strobe that has been brought into the bus clock domain. Software loads the count and reads it back as two 32-bit words. The low word carries bits 31..0. The high word carries bits 47..32 in its lower 16 bits and reads zero above them.

A 4-bit scale field picks a 32-bit window of the count, starting at bit `scale`. That window can be read at its own address. It is also compared against a 32-bit compare register. While the window is greater than or equal to the compare value, a pending flag in the configuration word is high and the interrupt output is high. Software clears the condition by raising the compare value or by reloading the count.

Top module: `aon_rtc_counter`

## Requirements
- R1: After reset the configuration, counter low and counter high words read 0, the compare word reads 0xFFFFFFFF, and `irq` is low.
- R2: While the enable bit (configuration bit 12) is 1, the count grows by exactly one in each clock cycle in which `tick_en` is high and no counter half is written, and it is unchanged in cycles with `tick_en` low.
- R3: While the enable bit is 0, `tick_en` has no effect on the count.
- R4: A write to the low word (offset 0x48) sets count bits 31..0 to the write data and leaves bits 47..32 unchanged. No tick is counted in that cycle.
- R5: A write to the high word (offset 0x4C) sets count bits 47..32 to write data bits 15..0 and leaves bits 31..0 unchanged. No tick is counted in that cycle. Reads of the high word return zero in bits 31..16.
- R6: The count wraps from 2^48-1 to 0 on the next counted tick, and a carry out of the low word increments the high word.
- R7: The scaled word at offset 0x50 reads count bits [scale+31 : scale], where scale is configuration bits 3..0.
- R8: Configuration bit 28 reads 1 exactly when the scaled word is greater than or equal to the compare word (offset 0x60, unsigned), and `irq` equals that bit.
- R9: In the configuration word (offset 0x40) only bits 3..0 and bit 12 are writable. Bit 28 ignores writes, and all other bits read zero.
- R10: Reads of unmapped offsets return zero. Writes to the scaled word or to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 9 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, valid in the same cycle as `bus_sel` |
| tick_en | input | 1 | One-cycle timebase tick |
| irq | output | 1 | High while the scaled count has reached the compare value |

## Verification
The bench loads the count through each half while ticks arrive. A design that keeps counting during a write, or that clears the other half, reads back one count too high or with the wrong half. The count is parked at all ones and just below a low-word carry. A missing carry or a bad wrap shows up as a wrong high word after one tick. All sixteen scale values are swept over an irregular 48-bit pattern, which exposes an off-by-one window or a truncated shift. The compare value is approached from below, hit exactly and passed, both unscaled and with a nonzero scale, so a strict `>` comparison or an irq that does not track the pending bit is caught at the boundary.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    // Word offsets decoded by the bus front end
    localparam int unsigned OFS_CFG    = 32'h40;
    localparam int unsigned OFS_CNT_LO = 32'h48;
    localparam int unsigned OFS_CNT_HI = 32'h4C;
    localparam int unsigned OFS_SCALED = 32'h50;
    localparam int unsigned OFS_CMP    = 32'h60;

    // Configuration word bit positions
    localparam int unsigned CFG_EN_BIT   = 12;
    localparam int unsigned CFG_PEND_BIT = 28;

    typedef struct packed {
        logic cfg;
        logic lo;
        logic hi;
        logic cmp;
    } wr_strobe_t;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_CFG,
        RSEL_LO,
        RSEL_HI,
        RSEL_SCALED,
        RSEL_CMP
    } rd_sel_t;

endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output wr_strobe_t        wstb,
    output rd_sel_t           rsel
);

    rd_sel_t hit;

    always_comb begin
        if      (bus_addr == ADDR_W'(OFS_CFG))    hit = RSEL_CFG;
        else if (bus_addr == ADDR_W'(OFS_CNT_LO)) hit = RSEL_LO;
        else if (bus_addr == ADDR_W'(OFS_CNT_HI)) hit = RSEL_HI;
        else if (bus_addr == ADDR_W'(OFS_SCALED)) hit = RSEL_SCALED;
        else if (bus_addr == ADDR_W'(OFS_CMP))    hit = RSEL_CMP;
        else                                      hit = RSEL_NONE;
    end

    always_comb begin
        wstb     = '0;
        rsel     = RSEL_NONE;
        if (bus_sel && bus_wr) begin
            wstb.cfg = (hit == RSEL_CFG);
            wstb.lo  = (hit == RSEL_LO);
            wstb.hi  = (hit == RSEL_HI);
            wstb.cmp = (hit == RSEL_CMP);
        end
        if (bus_sel && !bus_wr) begin
            rsel = hit;
        end
    end

endmodule

// File: rtl/rtc_count.sv
module rtc_count #(
    parameter int CNT_W  = 48,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt
);

    localparam int HI_W = CNT_W - DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo) begin
            st_d.cnt[DATA_W-1:0] = wdata;
        end
        if (wr_hi) begin
            st_d.cnt[CNT_W-1:DATA_W] = wdata[HI_W-1:0];
        end
        if (!wr_lo && !wr_hi && run) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/rtc_compare.sv
module rtc_compare #(
    parameter int CNT_W   = 48,
    parameter int DATA_W  = 32,
    parameter int SCALE_W = 4
) (
    input  logic [CNT_W-1:0]   cnt,
    input  logic [SCALE_W-1:0] scale,
    input  logic [DATA_W-1:0]  cmp,
    output logic [DATA_W-1:0]  scaled,
    output logic               pend
);

    localparam int NWIN = 2 ** SCALE_W;

    logic [DATA_W-1:0] win [NWIN];

    // One fixed window per scale value; the scale then picks among them
    for (genvar s = 0; s < NWIN; s++) begin : g_win
        assign win[s] = DATA_W'(cnt >> s);
    end

    assign scaled = win[scale];
    assign pend   = (scaled >= cmp);

endmodule

// File: rtl/aon_rtc_counter.sv
module aon_rtc_counter
    import rtc_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int CNT_W   = 48,
    parameter int DATA_W  = 32,
    parameter int SCALE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_en,
    output logic              irq
);

    localparam int HI_W = CNT_W - DATA_W;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic               en;
        logic [DATA_W-1:0]  cmp;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;

    wr_strobe_t        wstb;
    rd_sel_t           rsel;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] scaled;
    logic              pend;
    logic              wr_lo, wr_hi;

    rtc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wstb     (wstb),
        .rsel     (rsel)
    );

    assign wr_lo = wstb.lo;
    assign wr_hi = wstb.hi;

    rtc_count #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_q.en && tick_en),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    rtc_compare #(.CNT_W(CNT_W), .DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_cmp (
        .cnt    (cnt),
        .scale  (ctl_q.scale),
        .cmp    (ctl_q.cmp),
        .scaled (scaled),
        .pend   (pend)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wstb.cfg) begin
            ctl_d.scale = bus_wdata[SCALE_W-1:0];
            ctl_d.en    = bus_wdata[CFG_EN_BIT];
        end
        if (wstb.cmp) begin
            ctl_d.cmp = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{scale: '0, en: 1'b0, cmp: '1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (rsel)
            RSEL_CFG: begin
                bus_rdata[SCALE_W-1:0]  = ctl_q.scale;
                bus_rdata[CFG_EN_BIT]   = ctl_q.en;
                bus_rdata[CFG_PEND_BIT] = pend;
            end
            RSEL_LO:     bus_rdata = cnt[DATA_W-1:0];
            RSEL_HI:     bus_rdata = DATA_W'(cnt[CNT_W-1:DATA_W]);
            RSEL_SCALED: bus_rdata = scaled;
            RSEL_CMP:    bus_rdata = ctl_q.cmp;
            default:     bus_rdata = '0;
        endcase
    end

    assign irq = pend;

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
    import rtc_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int CNT_W   = 48,
    parameter int DATA_W  = 32,
    parameter int SCALE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tick_en,
    input logic              irq,
    input logic              en,
    input logic              wr_lo,
    input logic              wr_hi,
    input logic [CNT_W-1:0]  cnt
);

    localparam int HI_W = CNT_W - DATA_W;
    localparam logic [DATA_W-1:0] CFG_LIVE =
        DATA_W'((1 << SCALE_W) - 1) | (DATA_W'(1) << CFG_EN_BIT) | (DATA_W'(1) << CFG_PEND_BIT);

    logic rd_cfg, rd_hi, counting, no_wr;

    assign rd_cfg   = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
    assign rd_hi    = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_CNT_HI));
    assign counting = en && tick_en;
    assign no_wr    = !wr_lo && !wr_hi;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        counting && no_wr |=> cnt == $past(cnt) + CNT_W'(1)); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !counting && no_wr |=> $stable(cnt)); // R3

    AST_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cnt[DATA_W-1:0] == $past(bus_wdata))
              && (cnt[CNT_W-1:DATA_W] == $past(cnt[CNT_W-1:DATA_W]))); // R4

    AST_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (cnt[CNT_W-1:DATA_W] == $past(bus_wdata[HI_W-1:0]))
              && (cnt[DATA_W-1:0] == $past(cnt[DATA_W-1:0]))); // R5

    AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |-> bus_rdata[DATA_W-1:HI_W] == '0); // R5

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt) && counting && no_wr |=> cnt == '0); // R6

    AST_IRQ_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cfg |-> bus_rdata[CFG_PEND_BIT] == irq); // R8

    AST_CFG_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cfg |-> (bus_rdata & ~CFG_LIVE) == '0); // R9

endmodule

bind aon_rtc_counter rtc_checker #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .DATA_W  (DATA_W),
    .SCALE_W (SCALE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_en   (tick_en),
    .irq       (irq),
    .en        (ctl_q.en),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .cnt       (cnt)
);

// File: tb/aon_rtc_counter_test.sv
module aon_rtc_counter_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [8:0] A_CFG = 9'h040;
    localparam logic [8:0] A_LO  = 9'h048;
    localparam logic [8:0] A_HI  = 9'h04C;
    localparam logic [8:0] A_SC  = 9'h050;
    localparam logic [8:0] A_CMP = 9'h060;
    localparam logic [8:0] A_GAP = 9'h044;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    aon_rtc_counter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_en   (tick_en),
        .irq       (irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (all requirements): run hung, got %0d cycles expected < 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // Write occupies one clock edge; tick_en is driven alongside it
    task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic t);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = t;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    // Read is combinational; taken between edges
    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        logic [47:0] pat;
        int exp_cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(A_CFG, v); check("R1 cfg", v, 32'h0);
        rd(A_LO, v);  check("R1 lo", v, 32'h0);
        rd(A_HI, v);  check("R1 hi", v, 32'h0);
        rd(A_CMP, v); check("R1 cmp", v, 32'hFFFF_FFFF);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R3 disabled: ticks ignored
        ticks(5);
        rd(A_LO, v); check("R3 disabled ticks", v, 32'h0);

        // R9 writable bits only
        wr(A_CFG, 32'hFFFF_FFFF, 1'b0);
        rd(A_CFG, v); check("R9 cfg mask", v, 32'h0000_100F);
        wr(A_CFG, 32'h0000_1000, 1'b0);
        rd(A_CFG, v); check("R9 cfg enable only", v, 32'h0000_1000);

        // R2 irregular tick pattern
        exp_cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            tick_en = (i % 3 != 0);
            if (i % 3 != 0) exp_cnt++;
        end
        @(negedge clk);
        tick_en = 1'b0;
        rd(A_LO, v); check("R2 tick sweep", v, 32'(exp_cnt));

        // R3 disable again and tick
        wr(A_CFG, 32'h0, 1'b0);
        ticks(4);
        rd(A_LO, v); check("R3 hold when disabled", v, 32'(exp_cnt));
        wr(A_CFG, 32'h0000_1000, 1'b0);

        // R5 high half
        wr(A_HI, 32'hABCD_1234, 1'b0);
        rd(A_HI, v); check("R5 hi upper zero", v, 32'h0000_1234);
        rd(A_LO, v); check("R5 lo untouched", v, 32'(exp_cnt));

        // R4 low half written during a tick
        wr(A_LO, 32'hDEAD_BEEF, 1'b1);
        rd(A_LO, v); check("R4 lo paused write", v, 32'hDEAD_BEEF);
        rd(A_HI, v); check("R4 hi untouched", v, 32'h0000_1234);
        wr(A_HI, 32'h0000_0077, 1'b1);
        rd(A_LO, v); check("R5 lo paused on hi write", v, 32'hDEAD_BEEF);
        ticks(1);
        rd(A_LO, v); check("R2 single tick", v, 32'hDEAD_BEF0);

        // R6 wrap and carry
        wr(A_LO, 32'hFFFF_FFFF, 1'b0);
        wr(A_HI, 32'h0000_FFFF, 1'b0);
        ticks(1);
        rd(A_LO, v); check("R6 wrap lo", v, 32'h0);
        rd(A_HI, v); check("R6 wrap hi", v, 32'h0);
        wr(A_LO, 32'hFFFF_FFFF, 1'b0);
        wr(A_HI, 32'h0000_0001, 1'b0);
        ticks(1);
        rd(A_LO, v); check("R6 carry lo", v, 32'h0);
        rd(A_HI, v); check("R6 carry hi", v, 32'h0000_0002);

        // R7 scale sweep on a frozen pattern
        wr(A_CFG, 32'h0, 1'b0);
        pat = 48'h9A5C_3E71_D2B4;
        wr(A_LO, pat[31:0], 1'b0);
        wr(A_HI, 32'(pat[47:32]), 1'b0);
        for (int s = 0; s < 16; s++) begin
            wr(A_CFG, 32'(s), 1'b0);
            rd(A_SC, v); check($sformatf("R7 scale %0d", s), v, 32'(pat >> s));
        end

        // R8 compare boundary, scale 0
        wr(A_CFG, 32'h0, 1'b0);
        wr(A_HI, 32'h0, 1'b0);
        wr(A_CMP, 32'd100, 1'b0);
        for (int c = 97; c <= 103; c++) begin
            wr(A_LO, 32'(c), 1'b0);
            rd(A_CFG, v);
            check($sformatf("R8 pend cnt %0d", c), {31'b0, v[28]}, {31'b0, (c >= 100)});
            check($sformatf("R8 irq cnt %0d", c), {31'b0, irq}, {31'b0, (c >= 100)});
        end
        // R8 with scale 3
        wr(A_CFG, 32'h3, 1'b0);
        for (int c = 798; c <= 801; c++) begin
            wr(A_LO, 32'(c), 1'b0);
            check($sformatf("R8 irq scaled cnt %0d", c), {31'b0, irq}, {31'b0, ((c >> 3) >= 100)});
        end
        wr(A_CMP, 32'hFFFF_FFFF, 1'b0);
        check("R8 irq cleared by cmp", {31'b0, irq}, 32'h0);

        // R10 unmapped and read-only offsets
        rd(A_GAP, v); check("R10 unmapped read", v, 32'h0);
        wr(A_SC, 32'h0, 1'b0);
        wr(A_GAP, 32'hFFFF_FFFF, 1'b0);
        rd(A_SC, v);  check("R10 scaled unchanged", v, 32'(801 >> 3));
        rd(A_LO, v);  check("R10 lo unchanged", v, 32'd801);
        rd(A_HI, v);  check("R10 hi unchanged", v, 32'h0);
        rd(A_CFG, v); check("R10 cfg unchanged", v, 32'h3);
        rd(A_CMP, v); check("R10 cmp unchanged", v, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule